// File: doc/BRIEF.md
# Polled I/O Controller Host Interface

This block sits between a small microcontroller core that acts as an I/O controller and the host that polls it. The core builds an 8-bit result byte one nibble at a time. Each 5-bit write carries four data bits plus a tag bit that picks the half of the byte being replaced. The host reads that byte whenever it likes. Each host read also raises a request line toward the core for a fixed number of master-clock cycles. The core samples that line and uses it as its cue to produce the next value.

On the core side the block also provides a 3-bit operating mode, assembled from three single-bit latch locations. The mode is presented on a 4-bit mode input whose lowest bit is tied to zero. Four 4-bit input ports are offered to the core through a selector. A 4-bit auxiliary output written by the core is held and driven to the outside.

The default request length is 384 master cycles. That is one 48 kHz interface period when the master clock is 18.432 MHz. It gives a core running at about 4 µs per instruction enough time to see the pulse.

Top module: `pio_host_if`

## Requirements
- R1: A core nibble write whose bit 4 is 0 loads bits 3..0 of the write into bits 3..0 of the output byte and leaves bits 7..4 unchanged.
- R2: A core nibble write whose bit 4 is 1 loads bits 3..0 of the write into bits 7..4 of the output byte and leaves bits 3..0 unchanged.
- R3: The host read data always shows the output byte as it stands; a host read issued in the same cycle as a nibble write returns the value before that write.
- R4: A cycle with the host read strobe high sets the request output from the next cycle for exactly REQ_CYCLES cycles.
- R5: A host read while the request is already high restarts the count, so the request stays high for REQ_CYCLES cycles after the last read.
- R6: A mode latch write to address MODE_BASE+i (i = 0, 1, 2; default addresses 5, 6, 7) sets mode bit i to the written data bit; writes to any other address leave the mode unchanged.
- R7: The 4-bit mode input to the core carries the mode in bits 3..1 and a constant 0 in bit 0.
- R8: The core input data equals input port n (bits 4n+3..4n of the packed input bus) when the port select is n, for n = 0..3.
- R9: A core auxiliary write stores its 4 data bits on the auxiliary output the next cycle, where they are held until the next such write.
- R10: Reset clears the output byte, the mode, the auxiliary output and the request line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_nib_wr | input | 1 | Core nibble write enable |
| core_nib_word | input | 5 | Bit 4 = upper-half tag, bits 3..0 = nibble data |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_rd_data | output | 8 | Current output byte |
| core_req | output | 1 | Timed request toward the core |
| mode_wr | input | 1 | Mode latch write enable |
| mode_addr | input | 3 | Mode latch address |
| mode_bit | input | 1 | Data bit for the addressed latch |
| core_k | output | 4 | Mode input to the core, {mode, 0} |
| in_ports | input | 16 | Four packed 4-bit input ports |
| core_in_sel | input | 2 | Input port select |
| core_in_data | output | 4 | Selected input port |
| core_aux_wr | input | 1 | Auxiliary output write enable |
| core_aux_data | input | 4 | Auxiliary output data |
| aux_out | output | 4 | Held auxiliary output |

## Verification
The bench builds the block with REQ_CYCLES set to 5 and keeps MODE_BASE at 5. The short request means that full pulses, back-to-back retriggers and the exact falling cycle can all be observed within a few dozen cycles. The default address base exercises both the latch hits and the misses at the neighbouring addresses. A behavioural model follows the byte, the mode, the auxiliary output and the request countdown, and it is compared with the ports on every cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int MODE_W = 3;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Replace one half of a byte; upper selects bits 7..4.
  function automatic byte_t merge_nibble(byte_t cur, nib_t nib, logic upper);
    byte_t res;
    res = cur;
    if (upper) res[BYTE_W-1:NIB_W] = nib;
    else       res[NIB_W-1:0]      = nib;
    return res;
  endfunction
endpackage

// File: rtl/pio_nibble_reg.sv
module pio_nibble_reg
  import pio_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [NIB_W:0] wr_word,
  output byte_t          value
);
  logic  wr_upper;
  nib_t  wr_nib;

  assign wr_upper = wr_word[NIB_W];
  assign wr_nib   = wr_word[NIB_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (wr_en) value <= merge_nibble(value, wr_nib, wr_upper);
  end

  assert_lower_keeps_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_upper) |=> (value[BYTE_W-1:NIB_W] == $past(value[BYTE_W-1:NIB_W])
                              && value[NIB_W-1:0] == $past(wr_nib)));

  assert_upper_keeps_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_upper) |=> (value[NIB_W-1:0] == $past(value[NIB_W-1:0])
                             && value[BYTE_W-1:NIB_W] == $past(wr_nib)));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(value));
endmodule

// File: rtl/pio_req_timer.sv
module pio_req_timer #(
  parameter int CYCLES = 384,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic req
);
  logic [CNT_W-1:0] cnt;
  logic             expiring;

  assign expiring = !trigger && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (trigger)     cnt <= CNT_W'(CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign req = (cnt != '0);

  assert_read_raises_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> req);

  assert_req_falls_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(expiring));

  assert_retrigger_reloads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && req) |=> (cnt == CNT_W'(CYCLES)));
endmodule

// File: rtl/pio_mode_latch.sv
module pio_mode_latch #(
  parameter int ADDR_W = 3,
  parameter int MODE_W = 3,
  parameter int BASE   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bit_in,
  output logic [MODE_W-1:0] mode
);
  logic [MODE_W-1:0] hit;

  for (genvar i = 0; i < MODE_W; i++) begin : g_bit
    assign hit[i] = wr && (addr == ADDR_W'(BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode[i] <= 1'b0;
      else if (hit[i]) mode[i] <= bit_in;
    end
  end

  assert_miss_keeps_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit == '0) |=> $stable(mode));

  assert_single_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/pio_in_select.sv
module pio_in_select #(
  parameter int NUM = 4,
  parameter int W   = 4,
  localparam int SEL_W = $clog2(NUM)
) (
  input  logic [NUM*W-1:0] ports,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     data
);
  logic [W-1:0] lane [NUM];

  for (genvar n = 0; n < NUM; n++) begin : g_lane
    assign lane[n] = ports[n*W +: W];
  end

  always_comb begin
    data = '0;
    for (int n = 0; n < NUM; n++)
      if (sel == SEL_W'(n)) data = lane[n];
  end
endmodule

// File: rtl/pio_host_if.sv
module pio_host_if
  import pio_pkg::*;
#(
  parameter int REQ_CYCLES = 384,
  parameter int MODE_BASE  = 5,
  parameter int NUM_IN     = 4,
  localparam int SEL_W     = $clog2(NUM_IN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  core_nib_wr,
  input  logic [NIB_W:0]        core_nib_word,
  input  logic                  host_rd,
  output logic [BYTE_W-1:0]     host_rd_data,
  output logic                  core_req,
  input  logic                  mode_wr,
  input  logic [2:0]            mode_addr,
  input  logic                  mode_bit,
  output logic [MODE_W:0]       core_k,
  input  logic [NUM_IN*NIB_W-1:0] in_ports,
  input  logic [SEL_W-1:0]      core_in_sel,
  output logic [NIB_W-1:0]      core_in_data,
  input  logic                  core_aux_wr,
  input  logic [NIB_W-1:0]      core_aux_data,
  output logic [NIB_W-1:0]      aux_out
);
  byte_t             out_byte;
  logic [MODE_W-1:0] mode;

  pio_nibble_reg u_nib (
    .clk(clk), .rst_n(rst_n), .wr_en(core_nib_wr),
    .wr_word(core_nib_word), .value(out_byte)
  );

  pio_req_timer #(.CYCLES(REQ_CYCLES)) u_req (
    .clk(clk), .rst_n(rst_n), .trigger(host_rd), .req(core_req)
  );

  pio_mode_latch #(.ADDR_W(3), .MODE_W(MODE_W), .BASE(MODE_BASE)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .addr(mode_addr),
    .bit_in(mode_bit), .mode(mode)
  );

  pio_in_select #(.NUM(NUM_IN), .W(NIB_W)) u_in (
    .ports(in_ports), .sel(core_in_sel), .data(core_in_data)
  );

  assign host_rd_data = out_byte;
  assign core_k       = {mode, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           aux_out <= '0;
    else if (core_aux_wr) aux_out <= core_aux_data;
  end

  assert_aux_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_aux_wr |=> (aux_out == $past(core_aux_data)));

  assert_aux_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_aux_wr |=> $stable(aux_out));

  assert_nibble_reaches_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_nib_wr && !core_nib_word[NIB_W]) |=> (host_rd_data[NIB_W-1:0] == $past(core_nib_word[NIB_W-1:0])));
endmodule

// File: tb/pio_host_if_tb.sv
`timescale 1ns/1ps
module pio_host_if_tb;
  localparam int REQ = 5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        core_nib_wr = 0;
  logic [4:0]  core_nib_word = 0;
  logic        host_rd = 0;
  logic [7:0]  host_rd_data;
  logic        core_req;
  logic        mode_wr = 0;
  logic [2:0]  mode_addr = 0;
  logic        mode_bit = 0;
  logic [3:0]  core_k;
  logic [15:0] in_ports = 16'h0;
  logic [1:0]  core_in_sel = 0;
  logic [3:0]  core_in_data;
  logic        core_aux_wr = 0;
  logic [3:0]  core_aux_data = 0;
  logic [3:0]  aux_out;

  always #2.5 clk = ~clk;

  pio_host_if #(.REQ_CYCLES(REQ), .MODE_BASE(5), .NUM_IN(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_nib_wr(core_nib_wr), .core_nib_word(core_nib_word),
    .host_rd(host_rd), .host_rd_data(host_rd_data), .core_req(core_req),
    .mode_wr(mode_wr), .mode_addr(mode_addr), .mode_bit(mode_bit), .core_k(core_k),
    .in_ports(in_ports), .core_in_sel(core_in_sel), .core_in_data(core_in_data),
    .core_aux_wr(core_aux_wr), .core_aux_data(core_aux_data), .aux_out(aux_out)
  );

  int nchk = 0, nerr = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_byte, m_mode, m_aux, m_left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_byte = 0; m_mode = 0; m_aux = 0; m_left = 0;
    end else begin
      if (core_nib_wr) begin
        if (core_nib_word[4]) m_byte = (m_byte % 16) + 16 * core_nib_word[3:0];
        else                  m_byte = (m_byte / 16) * 16 + core_nib_word[3:0];
      end
      if (mode_wr && mode_addr >= 5) begin
        if (mode_bit) m_mode = m_mode | (1 << (mode_addr - 5));
        else          m_mode = m_mode & ~(1 << (mode_addr - 5));
      end
      if (core_aux_wr) m_aux = core_aux_data;
      if (host_rd) m_left = REQ;
      else if (m_left > 0) m_left = m_left - 1;
    end
  end

  // Per-cycle comparison and request run-length measurement
  int run = 0, last_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 host data vs model", host_rd_data, m_byte);
      chk("R4 request vs model", core_req, (m_left > 0) ? 1 : 0);
      chk("R7 mode input vs model", core_k, m_mode * 2);
      chk("R8 input select vs model", core_in_data, (in_ports >> (4 * core_in_sel)) & 15);
      chk("R9 aux vs model", aux_out, m_aux);
      if (core_req) run++;
      else if (run > 0) begin last_run = run; run = 0; end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic nib(int upper, int val);
    core_nib_wr = 1; core_nib_word = 5'(upper * 16 + val);
    step(); core_nib_wr = 0;
  endtask

  task automatic mwr(int a, int b);
    mode_wr = 1; mode_addr = 3'(a); mode_bit = b[0];
    step(); mode_wr = 0;
  endtask

  int cyc = 0;
  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=%0d expected<5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #1;
    step(); step();
    // R10: reset state
    chk("R10 byte after reset", host_rd_data, 0);
    chk("R10 request after reset", core_req, 0);
    chk("R10 mode after reset", core_k, 0);
    chk("R10 aux after reset", aux_out, 0);
    rst_n = 1;
    step();

    // R1 / R2 nibble assembly
    nib(0, 'hA); #1 chk("R1 lower write", host_rd_data, 'h0A);
    nib(1, 'h5); #1 chk("R2 upper write", host_rd_data, 'h5A);
    nib(0, 'h3); #1 chk("R1 lower keeps upper", host_rd_data, 'h53);
    nib(1, 'hF); #1 chk("R2 upper keeps lower", host_rd_data, 'hF3);

    // R3: read in same cycle as a write sees old value
    core_nib_wr = 1; core_nib_word = 5'h06; host_rd = 1;
    #1 chk("R3 read concurrent with write", host_rd_data, 'hF3);
    step(); core_nib_wr = 0; host_rd = 0;
    chk("R1 write after concurrent read", host_rd_data, 'hF6);
    repeat (REQ + 3) step();
    chk("R4 single read pulse length", last_run, REQ);

    // R5: retrigger
    host_rd = 1; step(); host_rd = 0; step();
    host_rd = 1; step(); host_rd = 0;
    repeat (REQ + 4) step();
    chk("R5 retriggered pulse length", last_run, REQ + 2);
    // Back-to-back reads held three cycles
    host_rd = 1; repeat (3) step(); host_rd = 0;
    repeat (REQ + 4) step();
    chk("R5 held read pulse length", last_run, REQ + 2);

    // R6 / R7 mode latch
    mwr(5, 1); #1 chk("R6 addr 5 sets bit 0", core_k, 4'b0010);
    mwr(7, 1); #1 chk("R6 addr 7 sets bit 2", core_k, 4'b1010);
    mwr(2, 0); mwr(4, 0); mwr(0, 0);
    #1 chk("R6 other addresses ignored", core_k, 4'b1010);
    mwr(6, 1); #1 chk("R7 all mode bits, K0 zero", core_k, 4'b1110);
    mwr(5, 0); #1 chk("R6 addr 5 clears bit 0", core_k, 4'b1100);

    // R8 input ports
    in_ports = 16'hC4B9;
    for (int n = 0; n < 4; n++) begin
      core_in_sel = 2'(n); #1;
      chk("R8 port select", core_in_data, (16'hC4B9 >> (4 * n)) & 15);
    end

    // R9 aux output
    core_aux_wr = 1; core_aux_data = 4'h9; step(); core_aux_wr = 0;
    core_aux_data = 4'h2; step();
    chk("R9 aux stored and held", aux_out, 9);

    // Mixed traffic against the model
    for (int i = 0; i < 60; i++) begin
      core_nib_wr = (i % 3 == 0); core_nib_word = 5'((i * 7) % 32);
      host_rd = (i % 11 == 0); mode_wr = (i % 4 == 1);
      mode_addr = 3'(i % 8); mode_bit = i[1];
      core_in_sel = 2'(i % 4); in_ports = 16'(i * 1237);
      core_aux_wr = (i % 5 == 2); core_aux_data = 4'(i);
      step();
    end
    core_nib_wr = 0; host_rd = 0; mode_wr = 0; core_aux_wr = 0;
    repeat (REQ + 2) step();

    // R10: reset mid-operation
    host_rd = 1; step(); host_rd = 0;
    rst_n = 0; #1;
    chk("R10 async reset clears byte", host_rd_data, 0);
    chk("R10 async reset clears request", core_req, 0);
    chk("R10 async reset clears aux", aux_out, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule